// File: doc/BRIEF.md
# Prioritized Autovector Interrupt Controller

This block gathers thirteen level-sensitive interrupt lines, numbered 1 to 13, and presents one request to the processor. The request is a 3-bit interrupt level and an 8-bit vector number. Each source has an 8-bit control byte. The low five bits of that byte are the arbitration key: the upper three bits of the key are the interrupt level and the lower two bits order sources within that level. Bit 7 of the control byte makes the source autovectored.

A mask register blocks individual sources. A pending register copies the input lines on every clock. The largest key among the unmasked pending sources wins. A winning key below 4 requests nothing. Otherwise the vector is either 24 plus the level, or it comes from a vector register chosen by the winning source. Software reaches the control bytes, the mask, the pending image, the vector registers and a write-one-to-clear reset-status byte through a simple synchronous register port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A source is active only when its pending bit is 1 and its mask bit is 0. Bit i of the mask and pending registers belongs to source i. Line 0 and mask bit 0 have no effect.
- R2: Among active sources, the source with the largest control bits 4:0 wins. Between equal values, the lower-numbered source wins.
- R3: When no source is active, or the winning 5-bit key is below 4, the level output is 0 and the vector output is 0.
- R4: The level output equals bits 4:2 of the winner's control byte.
- R5: When bit 7 of the winner's control byte is 1, the vector is 24 plus the level.
- R6: When bit 7 is 0, source 8 takes the watchdog vector register, source 12 takes vector register A, source 13 takes vector register B, and every other source gives 0x0F.
- R7: After reset, the control bytes of sources 1 to 7 are 4 times the source number. Source 8 is 0x1C, sources 9 to 11 are 0x80, and sources 12 and 13 are 0x00. The mask is 0x3FFE, reset status is 0x80, and the watchdog vector, vector A and vector B are each 0x0F.
- R8: Byte address map: the control byte of source n is at 0x13+n, the mask at 0x36, pending at 0x3A, reset status at 0x40, the watchdog vector at 0x42, vector A at 0x70 and vector B at 0x71. Reads of any other address return 0.
- R9: The pending register holds the value the input lines had at the previous clock edge. Register-port writes to it are ignored.
- R10: A write to reset status clears each bit written as 1 and leaves the other bits unchanged. No bit is ever set after reset.
- R11: The level and vector outputs reflect a register write or an input change from the clock edge that captures it. They do not change before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_src_i | input | 14 | Source lines; bit i is source i, bit 0 unused |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i (combinational) |
| irq_level_o | output | 3 | Requested interrupt level, 0 when idle |
| irq_vector_o | output | 8 | Vector number for the request |

## Verification
A corrupted mask or pending bit makes a blocked source win, or hides a legal winner. This shows on the level output in the first cycle after the capturing edge. A control byte that is wrong in its low five bits shifts the winner or its level at once. A wrong bit 7 or a wrong vector register shows only in the vector, and only while that source is the winner. For that reason the vector paths are exercised with each source class winning in turn. Reset-status and pending corruption are visible only through reads, so those are read back directly after each stimulus.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 16;
    localparam int CTRL_BASE  = 'h13;
    localparam int ADR_MASK   = 'h36;
    localparam int ADR_PEND   = 'h3A;
    localparam int ADR_RSTAT  = 'h40;
    localparam int ADR_WDVEC  = 'h42;
    localparam int ADR_VEC_A  = 'h70;
    localparam int ADR_VEC_B  = 'h71;
    localparam int SRC_WDOG   = 8;
    localparam int SRC_VEC_A  = 12;
    localparam int SRC_VEC_B  = 13;
    localparam int KEY_MIN    = 4;
    localparam int AUTO_BASE  = 24;
    localparam logic [7:0] VEC_DEFAULT = 8'h0F;
    localparam logic [7:0] RSTAT_INIT  = 8'h80;

    function automatic logic [7:0] ctrl_reset(input int n);
        if (n >= 1 && n <= 7)       return 8'(n * 4);
        else if (n == 8)            return 8'h1C;
        else if (n >= 9 && n <= 11) return 8'h80;
        else                        return 8'h00;
    endfunction
endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
    import prio_irq_pkg::*;
#(
    parameter int NSRC = 13
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NSRC:0]            src_i,
    input  logic                     we_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [DATA_W-1:0]        wdata_i,
    output logic [DATA_W-1:0]        rdata_o,
    output logic [NSRC:0][7:0]       ctrl_o,
    output logic [NSRC:0]            mask_o,
    output logic [NSRC:0]            pend_o,
    output logic [7:0]               wdvec_o,
    output logic [7:0]               vec_a_o,
    output logic [7:0]               vec_b_o
);
    typedef struct packed {
        logic [NSRC:0][7:0] ctrl;
        logic [NSRC:0]      mask;
        logic [NSRC:0]      pend;
        logic [7:0]         rstat;
        logic [7:0]         wdvec;
        logic [7:0]         vec_a;
        logic [7:0]         vec_b;
    } regs_t;

    regs_t r_d, r_q;

    function automatic regs_t regs_init();
        regs_t v;
        v.ctrl = '0;
        for (int i = 1; i <= NSRC; i++) v.ctrl[i] = ctrl_reset(i);
        v.mask    = {{NSRC{1'b1}}, 1'b0};
        v.pend    = '0;
        v.rstat   = RSTAT_INIT;
        v.wdvec   = VEC_DEFAULT;
        v.vec_a   = VEC_DEFAULT;
        v.vec_b   = VEC_DEFAULT;
        return v;
    endfunction

    always_comb begin
        r_d         = r_q;
        r_d.pend    = src_i;
        r_d.pend[0] = 1'b0;
        if (we_i) begin
            for (int i = 1; i <= NSRC; i++) begin
                if (addr_i == ADDR_W'(CTRL_BASE + i)) r_d.ctrl[i] = wdata_i[7:0];
            end
            case (addr_i)
                ADDR_W'(ADR_MASK):  r_d.mask  = wdata_i[NSRC:0];
                ADDR_W'(ADR_RSTAT): r_d.rstat = r_q.rstat & ~wdata_i[7:0];
                ADDR_W'(ADR_WDVEC): r_d.wdvec = wdata_i[7:0];
                ADDR_W'(ADR_VEC_A): r_d.vec_a = wdata_i[7:0];
                ADDR_W'(ADR_VEC_B): r_d.vec_b = wdata_i[7:0];
                default: ;
            endcase
        end
        r_d.ctrl[0] = '0;
        r_d.mask[0] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= regs_init();
        else        r_q <= r_d;
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 1; i <= NSRC; i++) begin
            if (addr_i == ADDR_W'(CTRL_BASE + i)) rdata_o = DATA_W'(r_q.ctrl[i]);
        end
        case (addr_i)
            ADDR_W'(ADR_MASK):  rdata_o = DATA_W'(r_q.mask);
            ADDR_W'(ADR_PEND):  rdata_o = DATA_W'(r_q.pend);
            ADDR_W'(ADR_RSTAT): rdata_o = DATA_W'(r_q.rstat);
            ADDR_W'(ADR_WDVEC): rdata_o = DATA_W'(r_q.wdvec);
            ADDR_W'(ADR_VEC_A): rdata_o = DATA_W'(r_q.vec_a);
            ADDR_W'(ADR_VEC_B): rdata_o = DATA_W'(r_q.vec_b);
            default: ;
        endcase
    end

    assign ctrl_o  = r_q.ctrl;
    assign mask_o  = r_q.mask;
    assign pend_o  = r_q.pend;
    assign wdvec_o = r_q.wdvec;
    assign vec_a_o = r_q.vec_a;
    assign vec_b_o = r_q.vec_b;

    // Reset status only ever loses bits once out of reset
    assert_rstat_no_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.rstat & ~$past(r_q.rstat)) == 8'h00);
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
    import prio_irq_pkg::*;
#(
    parameter int NSRC = 13,
    localparam int IW  = $clog2(NSRC + 1)
) (
    input  logic [NSRC:0][7:0] ctrl_i,
    input  logic [NSRC:0]      active_i,
    output logic [IW-1:0]      win_o,
    output logic               hit_o
);
    logic [4:0]    best;
    logic [IW-1:0] idx;

    always_comb begin
        best = '0;
        idx  = '0;
        for (int i = 1; i <= NSRC; i++) begin
            if (active_i[i] && (ctrl_i[i][4:0] > best)) begin
                best = ctrl_i[i][4:0];
                idx  = IW'(i);
            end
        end
    end

    assign win_o = idx;
    assign hit_o = (best >= 5'(KEY_MIN));
endmodule

// File: rtl/prio_irq_vec.sv
module prio_irq_vec
    import prio_irq_pkg::*;
#(
    parameter int NSRC = 13,
    localparam int IW  = $clog2(NSRC + 1)
) (
    input  logic          hit_i,
    input  logic [IW-1:0] win_i,
    input  logic [7:0]    ctrl_i,
    input  logic [7:0]    wdvec_i,
    input  logic [7:0]    vec_a_i,
    input  logic [7:0]    vec_b_i,
    output logic [2:0]    level_o,
    output logic [7:0]    vector_o
);
    always_comb begin
        level_o  = hit_i ? ctrl_i[4:2] : 3'd0;
        vector_o = 8'h00;
        if (hit_i) begin
            if (ctrl_i[7]) begin
                vector_o = 8'(AUTO_BASE) + 8'(ctrl_i[4:2]);
            end else if (win_i == IW'(SRC_WDOG)) begin
                vector_o = wdvec_i;
            end else if (win_i == IW'(SRC_VEC_A)) begin
                vector_o = vec_a_i;
            end else if (win_i == IW'(SRC_VEC_B)) begin
                vector_o = vec_b_i;
            end else begin
                vector_o = VEC_DEFAULT;
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NSRC = 13,
    localparam int IW  = $clog2(NSRC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC:0]     irq_src_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic [2:0]        irq_level_o,
    output logic [7:0]        irq_vector_o
);
    logic [NSRC:0][7:0] ctrl;
    logic [NSRC:0]      mask, pend, active;
    logic [7:0]         wdvec, vec_a, vec_b;
    logic [IW-1:0]      win;
    logic               hit;
    logic [7:0]         win_ctrl;

    prio_irq_regs #(.NSRC(NSRC)) u_regs (
        .clk(clk), .rst_n(rst_n), .src_i(irq_src_i),
        .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
        .rdata_o(reg_rdata_o), .ctrl_o(ctrl), .mask_o(mask), .pend_o(pend),
        .wdvec_o(wdvec), .vec_a_o(vec_a), .vec_b_o(vec_b)
    );

    assign active = pend & ~mask;

    prio_irq_arb #(.NSRC(NSRC)) u_arb (
        .ctrl_i(ctrl), .active_i(active), .win_o(win), .hit_o(hit)
    );

    assign win_ctrl = ctrl[win];

    prio_irq_vec #(.NSRC(NSRC)) u_vec (
        .hit_i(hit), .win_i(win), .ctrl_i(win_ctrl),
        .wdvec_i(wdvec), .vec_a_i(vec_a), .vec_b_i(vec_b),
        .level_o(irq_level_o), .vector_o(irq_vector_o)
    );

    logic chk_vld_d, chk_vld_q;
    assign chk_vld_d = 1'b1;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_vld_q <= 1'b0;
        else        chk_vld_q <= chk_vld_d;
    end

    assert_winner_active_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level_o != 3'd0) |-> (pend[win] && !mask[win] && win != '0));
    assert_idle_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level_o == 3'd0) |-> (irq_vector_o == 8'h00));
    assert_autovector_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level_o != 3'd0 && win_ctrl[7]) |-> (irq_vector_o == 8'd24 + 8'(irq_level_o)));
    assert_pending_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chk_vld_q |-> (pend[NSRC:1] == $past(irq_src_i[NSRC:1]) && !pend[0]));
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] src = '0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [2:0]  lvl;
    logic [7:0]  vec;
    int          n_chk = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_src_i(src), .reg_we_i(we),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .irq_level_o(lvl), .irq_vector_o(vec)
    );

    // {src[13:0], mask[13:0], level[2:0], vector[7:0]}, default control bytes
    localparam int NV = 10;
    localparam logic [38:0] TBL [NV] = '{
        {14'h0000, 14'h0000, 3'd0, 8'h00},
        {14'h0002, 14'h0000, 3'd1, 8'h0F},
        {14'h0028, 14'h0000, 3'd5, 8'h0F},
        {14'h0180, 14'h0000, 3'd7, 8'h0F},
        {14'h0200, 14'h0000, 3'd0, 8'h00},
        {14'h0004, 14'h0004, 3'd0, 8'h00},
        {14'h0042, 14'h0040, 3'd1, 8'h0F},
        {14'h0001, 14'h0000, 3'd0, 8'h00},
        {14'h0014, 14'h0000, 3'd4, 8'h0F},
        {14'h0180, 14'h0080, 3'd7, 8'h0F}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [15:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic drive_src(input logic [13:0] s);
        @(negedge clk);
        src = s;
        @(negedge clk);
    endtask

    task automatic out_chk(input string req, input logic [2:0] el, input logic [7:0] ev);
        check(req, {13'd0, lvl}, {13'd0, el});
        check(req, {8'd0, vec}, {8'd0, ev});
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset values, read through the R8 map
        out_chk("R7 idle after reset", 3'd0, 8'h00);
        rd_chk("R7 ctrl s1", 8'h14, 16'h0004);
        rd_chk("R7 ctrl s7", 8'h1A, 16'h001C);
        rd_chk("R7 ctrl s8", 8'h1B, 16'h001C);
        rd_chk("R7 ctrl s9", 8'h1C, 16'h0080);
        rd_chk("R7 ctrl s13", 8'h20, 16'h0000);
        rd_chk("R7 mask", 8'h36, 16'h3FFE);
        rd_chk("R7 rstat", 8'h40, 16'h0080);
        rd_chk("R7 wdvec", 8'h42, 16'h000F);
        rd_chk("R7 vecA", 8'h70, 16'h000F);
        rd_chk("R8 unmapped read", 8'h50, 16'h0000);
        // R11: default mask blocks everything, even a live line
        drive_src(14'h0080);
        out_chk("R1 masked by reset mask", 3'd0, 8'h00);

        // Table walk: R1 R2 R3 R4 R6
        for (int k = 0; k < NV; k++) begin
            wr(8'h36, {2'b00, TBL[k][24:11]});
            drive_src(TBL[k][38:25]);
            out_chk($sformatf("R1/R2/R4 vector row %0d", k), TBL[k][10:8], TBL[k][7:0]);
        end

        // R11 latency: output waits for the capturing edge
        wr(8'h36, 16'h0000);
        drive_src(14'h0000);
        @(negedge clk);
        src = 14'h0080;
        #1;
        out_chk("R11 before edge", 3'd0, 8'h00);
        @(negedge clk);
        out_chk("R11 after edge", 3'd7, 8'h0F);

        // R6 watchdog vector and R2 tie
        wr(8'h42, 16'h0040);
        drive_src(14'h0180);
        out_chk("R2 tie lowest wins", 3'd7, 8'h0F);
        wr(8'h36, 16'h0080);
        out_chk("R6 watchdog vector", 3'd7, 8'h40);
        wr(8'h36, 16'h0000);

        // R5 autovector
        wr(8'h1C, 16'h0094);
        drive_src(14'h0200);
        out_chk("R5 autovector s9", 3'd5, 8'd29);

        // R6 vector registers A and B
        wr(8'h1F, 16'h0018);
        wr(8'h20, 16'h000C);
        wr(8'h70, 16'h0055);
        wr(8'h71, 16'h0066);
        drive_src(14'h2000);
        out_chk("R6 vector B", 3'd3, 8'h66);
        drive_src(14'h3000);
        out_chk("R6 vector A wins", 3'd6, 8'h55);

        // R6 other source gives 0x0F
        wr(8'h1D, 16'h0010);
        drive_src(14'h0400);
        out_chk("R6 other source", 3'd4, 8'h0F);

        // R3 threshold boundary
        wr(8'h14, 16'h0003);
        drive_src(14'h0002);
        out_chk("R3 key 3 idle", 3'd0, 8'h00);
        wr(8'h14, 16'h0004);
        out_chk("R3 key 4 fires", 3'd1, 8'h0F);

        // R2 low key bits order within a level, R4 level field
        wr(8'h15, 16'h0009);
        wr(8'h16, 16'h008A);
        drive_src(14'h000C);
        out_chk("R2 low bits decide", 3'd2, 8'd26);

        // R9 pending image, writes ignored
        drive_src(14'h0022);
        rd_chk("R9 pending read", 8'h3A, 16'h0022);
        wr(8'h3A, 16'hFFFF);
        rd_chk("R9 pending write ignored", 8'h3A, 16'h0022);
        out_chk("R9 output unchanged", 3'd5, 8'h0F);

        // R10 write-one-to-clear
        wr(8'h40, 16'h0000);
        rd_chk("R10 zero write keeps", 8'h40, 16'h0080);
        wr(8'h40, 16'h0080);
        rd_chk("R10 one clears", 8'h40, 16'h0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule